// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the bit timing a CAN controller needs. A programmable prescaler cuts the clock into time quanta. Each bit is then laid out as one sync quantum, a first phase segment and a second phase segment. At the point where the first phase segment ends, the block takes the receive line and reports the bit value with a one-cycle strobe. A second strobe marks the first cycle of every bit, and the transmit side uses it to launch the next bit. When triple sampling is selected, the bit value is the majority of three readings taken one quantum apart, the last of them on the nominal sample point.

Each timing field holds the wanted count minus one, and the hardware adds one when it uses the field. The fields can be written only while the configuration acknowledge is high. To get it, the controller raises a change request. The acknowledge rises only once the bit in flight has finished. While the acknowledge is high the timing engine is idle. When the request is withdrawn, the acknowledge drops on the next clock and a fresh bit begins at once. After reset the block is in configuration mode with every field at zero.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, cfg_ack_o is 1, all field readbacks are 0, bit_o is 1, and sample_o and bit_start_o are 0.
- R2: A write (wr_en_i high at a clock edge) updates the prescaler, phase-1, phase-2 and triple-sampling fields only while cfg_ack_o is 1. Otherwise the write is ignored and the readbacks keep their values.
- R3: While running, a raised cfg_req_i sets cfg_ack_o only at the edge that ends the last quantum of a bit. cfg_ack_o is first seen high in the cycle right after that bit.
- R4: While cfg_ack_o is 1 and cfg_req_i is 0, cfg_ack_o drops at the next edge. The first cycle with cfg_ack_o low is the first cycle of a bit.
- R5: A quantum lasts (prescaler field + 1) clocks. A bit lasts 1 + (phase-1 field + 1) + (phase-2 field + 1) quanta. bit_start_o is high for exactly the first clock of each bit.
- R6: sample_o pulses for one clock, (phase-1 field + 2) quanta after the bit start. In single mode, bit_o takes the value rx_i had in the last clock of the phase-1 segment.
- R7: With the triple field at 1, bit_o is the majority of rx_i taken at the ends of three quanta: the last quantum of phase-1 and the two quanta before it.
- R8: With the triple field at 1 and the phase-2 field at 0, phase-2 lasts 2 quanta.
- R9: While cfg_ack_o is 1, sample_o and bit_start_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_req_i | input | 1 | Configuration change request (level) |
| cfg_ack_o | output | 1 | Configuration window granted; engine idle |
| wr_en_i | input | 1 | Timing register write strobe |
| wr_presc_i | input | PRESC_W | Prescaler field (clocks per quantum minus one) |
| wr_ph1_i | input | PH1_W | Phase-1 field (quanta minus one) |
| wr_ph2_i | input | PH2_W | Phase-2 field (quanta minus one) |
| wr_triple_i | input | 1 | Triple-sampling select |
| rd_presc_o | output | PRESC_W | Prescaler field readback |
| rd_ph1_o | output | PH1_W | Phase-1 field readback |
| rd_ph2_o | output | PH2_W | Phase-2 field readback |
| rd_triple_o | output | 1 | Triple-sampling readback |
| rx_i | input | 1 | Receive line, synchronous to clk_i |
| sample_o | output | 1 | One-cycle strobe: bit_o updated |
| bit_o | output | 1 | Sampled bit value |
| bit_start_o | output | 1 | One-cycle strobe on the first clock of a bit |

## Verification
Several properties are checked on every cycle. Both strobes stay silent in configuration mode, and neither lasts more than one clock. The acknowledge rises only after a bit has ended with the request set. Leaving configuration mode starts a bit. The fields never change while the window is closed. Only the bench scenarios can show the cycle positions that depend on the fields: quantum length, bit period, sample position, the phase-2 clamp, and the majority result for chosen patterns on the receive line.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic {SMP_SINGLE = 1'b0, SMP_TRIPLE = 1'b1} smp_mode_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/can_bt_regs.sv
module can_bt_regs #(
  parameter int PRESC_W = 10,
  parameter int PH1_W   = 4,
  parameter int PH2_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_req_i,
  input  logic               bit_end_i,
  input  logic               wr_en_i,
  input  logic [PRESC_W-1:0] wr_presc_i,
  input  logic [PH1_W-1:0]   wr_ph1_i,
  input  logic [PH2_W-1:0]   wr_ph2_i,
  input  logic               wr_triple_i,
  output logic               cfg_ack_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [PH1_W-1:0]   ph1_o,
  output logic [PH2_W-1:0]   ph2_o,
  output can_bt_pkg::smp_mode_e mode_o
);
  import can_bt_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_ack_o <= 1'b1;
    end else if (cfg_ack_o && !cfg_req_i) begin
      cfg_ack_o <= 1'b0;
    end else if (!cfg_ack_o && cfg_req_i && bit_end_i) begin
      cfg_ack_o <= 1'b1;  // grant only on a bit boundary
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_o <= '0;
      ph1_o   <= '0;
      ph2_o   <= '0;
      mode_o  <= SMP_SINGLE;
    end else if (cfg_ack_o && wr_en_i) begin
      presc_o <= wr_presc_i;
      ph1_o   <= wr_ph1_i;
      ph2_o   <= wr_ph2_i;
      mode_o  <= smp_mode_e'(wr_triple_i);
    end
  end
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int PRESC_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o,
  output logic               first_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o  = run_i && (cnt_q == presc_i);
  assign first_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq #(
  parameter int PH1_W = 4,
  parameter int PH2_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PH1_W-1:0] ph1_i,
  input  logic [PH2_W-1:0] ph2_i,
  input  can_bt_pkg::smp_mode_e mode_i,
  output logic             first_o,
  output logic             bit_end_o,
  output logic             smp_tick_o
);
  import can_bt_pkg::*;

  localparam int MAX_Q = (2 ** PH1_W) + (2 ** PH2_W) + 1;
  localparam int Q_W   = $clog2(MAX_Q + 1);

  logic [Q_W-1:0]   q_cnt;
  logic [PH2_W-1:0] ph2_eff;
  logic [Q_W-1:0]   last_q;
  logic [Q_W-1:0]   smp_q;

  // triple sampling needs at least two phase-2 quanta
  assign ph2_eff = (mode_i == SMP_TRIPLE && ph2_i == '0) ? PH2_W'(1) : ph2_i;
  assign last_q  = Q_W'(ph1_i) + Q_W'(ph2_eff) + Q_W'(2);
  assign smp_q   = Q_W'(ph1_i) + Q_W'(1);

  assign first_o    = (q_cnt == '0);
  assign bit_end_o  = tick_i && (q_cnt == last_q);
  assign smp_tick_o = tick_i && (q_cnt == smp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_cnt <= '0;
    else if (!run_i)     q_cnt <= '0;
    else if (bit_end_o)  q_cnt <= '0;
    else if (tick_i)     q_cnt <= q_cnt + 1'b1;
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic smp_tick_i,
  input  logic rx_i,
  input  can_bt_pkg::smp_mode_e mode_i,
  output logic sample_o,
  output logic bit_o
);
  import can_bt_pkg::*;

  logic [1:0] hist_q;  // rx at the two previous quantum ends

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q   <= 2'b11;
      sample_o <= 1'b0;
      bit_o    <= 1'b1;
    end else begin
      sample_o <= smp_tick_i;
      if (tick_i) hist_q <= {hist_q[0], rx_i};
      if (smp_tick_i) begin
        bit_o <= (mode_i == SMP_TRIPLE) ? maj3(hist_q[1], hist_q[0], rx_i) : rx_i;
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRESC_W = 10,
  parameter int PH1_W   = 4,
  parameter int PH2_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_req_i,
  output logic               cfg_ack_o,
  input  logic               wr_en_i,
  input  logic [PRESC_W-1:0] wr_presc_i,
  input  logic [PH1_W-1:0]   wr_ph1_i,
  input  logic [PH2_W-1:0]   wr_ph2_i,
  input  logic               wr_triple_i,
  output logic [PRESC_W-1:0] rd_presc_o,
  output logic [PH1_W-1:0]   rd_ph1_o,
  output logic [PH2_W-1:0]   rd_ph2_o,
  output logic               rd_triple_o,
  input  logic               rx_i,
  output logic               sample_o,
  output logic               bit_o,
  output logic               bit_start_o
);
  import can_bt_pkg::*;

  logic      run;
  logic      tick;
  logic      presc_first;
  logic      q_first;
  logic      bit_end;
  logic      smp_tick;
  smp_mode_e mode;

  assign run         = !cfg_ack_o;
  assign rd_triple_o = (mode == SMP_TRIPLE);
  assign bit_start_o = run && presc_first && q_first;

  can_bt_regs #(.PRESC_W(PRESC_W), .PH1_W(PH1_W), .PH2_W(PH2_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_req_i   (cfg_req_i),
    .bit_end_i   (bit_end),
    .wr_en_i     (wr_en_i),
    .wr_presc_i  (wr_presc_i),
    .wr_ph1_i    (wr_ph1_i),
    .wr_ph2_i    (wr_ph2_i),
    .wr_triple_i (wr_triple_i),
    .cfg_ack_o   (cfg_ack_o),
    .presc_o     (rd_presc_o),
    .ph1_o       (rd_ph1_o),
    .ph2_o       (rd_ph2_o),
    .mode_o      (mode)
  );

  can_bt_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .presc_i (rd_presc_o),
    .tick_o  (tick),
    .first_o (presc_first)
  );

  can_bt_seq #(.PH1_W(PH1_W), .PH2_W(PH2_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .ph1_i      (rd_ph1_o),
    .ph2_i      (rd_ph2_o),
    .mode_i     (mode),
    .first_o    (q_first),
    .bit_end_o  (bit_end),
    .smp_tick_o (smp_tick)
  );

  can_bt_sampler u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .smp_tick_i (smp_tick),
    .rx_i       (rx_i),
    .mode_i     (mode),
    .sample_o   (sample_o),
    .bit_o      (bit_o)
  );
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker #(
  parameter int PRESC_W = 10,
  parameter int PH1_W   = 4,
  parameter int PH2_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_req_i,
  input logic               cfg_ack_o,
  input logic               bit_end,
  input logic               sample_o,
  input logic               bit_start_o,
  input logic [PRESC_W-1:0] rd_presc_o,
  input logic [PH1_W-1:0]   rd_ph1_o,
  input logic [PH2_W-1:0]   rd_ph2_o,
  input logic               rd_triple_o
);
  a_r9_quiet_in_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ack_o |-> (!sample_o && !bit_start_o));

  a_r3_grant_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_ack_o) |-> ($past(bit_end) && $past(cfg_req_i)));

  a_r4_exit_starts_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_ack_o) |-> bit_start_o);

  a_r2_fields_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ack_o |=> ($stable(rd_presc_o) && $stable(rd_ph1_o) &&
                    $stable(rd_ph2_o) && $stable(rd_triple_o)));

  a_r6_sample_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  a_r5_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |=> !bit_start_o);
endmodule

bind can_bit_timer can_bt_checker #(.PRESC_W(PRESC_W), .PH1_W(PH1_W), .PH2_W(PH2_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_req_i   (cfg_req_i),
  .cfg_ack_o   (cfg_ack_o),
  .bit_end     (bit_end),
  .sample_o    (sample_o),
  .bit_start_o (bit_start_o),
  .rd_presc_o  (rd_presc_o),
  .rd_ph1_o    (rd_ph1_o),
  .rd_ph2_o    (rd_ph2_o),
  .rd_triple_o (rd_triple_o)
);

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
  localparam int PRESC_W = 10;
  localparam int PH1_W   = 4;
  localparam int PH2_W   = 3;

  typedef struct packed {
    int presc;
    int ph1;
    int ph2;
    int triple;
    int lowpat;  // bit0: sampling clock, bit1: one quantum earlier, bit2: two earlier
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{0, 4, 1, 0, 1},
    '{2, 10, 2, 0, 6},
    '{9, 6, 1, 0, 0},
    '{1, 7, 5, 1, 1},
    '{0, 3, 0, 1, 3},
    '{4, 9, 3, 0, 4},
    '{0, 1, 2, 1, 5},
    '{3, 2, 0, 1, 6}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_req_i = 1'b1;
  logic cfg_ack_o;
  logic wr_en_i = 1'b0;
  logic [PRESC_W-1:0] wr_presc_i = '0;
  logic [PH1_W-1:0]   wr_ph1_i = '0;
  logic [PH2_W-1:0]   wr_ph2_i = '0;
  logic wr_triple_i = 1'b0;
  logic [PRESC_W-1:0] rd_presc_o;
  logic [PH1_W-1:0]   rd_ph1_o;
  logic [PH2_W-1:0]   rd_ph2_o;
  logic rd_triple_o;
  logic rx_i = 1'b1;
  logic sample_o;
  logic bit_o;
  logic bit_start_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  can_bit_timer #(.PRESC_W(PRESC_W), .PH1_W(PH1_W), .PH2_W(PH2_W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_vec(input vec_t v);
    int b, p2, nq, period, smp, s, first_smp, second_start, ack_rise, smp_bit, lows, exp_bit;
    b  = v.presc + 1;
    p2 = (v.triple != 0 && v.ph2 == 0) ? 2 : v.ph2 + 1;
    nq = 1 + (v.ph1 + 1) + p2;
    period = nq * b;
    smp = (v.ph1 + 2) * b;
    s = smp - 1;
    lows = (v.lowpat & 1) + ((v.lowpat >> 1) & 1) + ((v.lowpat >> 2) & 1);
    exp_bit = (v.triple != 0) ? (lows >= 2 ? 0 : 1) : ((v.lowpat & 1) ? 0 : 1);
    first_smp = -1; second_start = -1; ack_rise = -1; smp_bit = -1;

    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_presc_i = PRESC_W'(v.presc);
    wr_ph1_i = PH1_W'(v.ph1);
    wr_ph2_i = PH2_W'(v.ph2);
    wr_triple_i = (v.triple != 0);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R2 presc written in window", int'(rd_presc_o), v.presc);
    chk("R2 ph1 written in window", int'(rd_ph1_o), v.ph1);
    cfg_req_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R4 ack falls", int'(cfg_ack_o), 0);
    chk("R4 first running cycle starts bit", int'(bit_start_o), 1);
    for (int k = 0; k <= 2 * period + 2; k++) begin
      rx_i = 1'b1;
      if (k < period) begin
        if (((v.lowpat & 1) != 0) && k == s) rx_i = 1'b0;
        if (((v.lowpat & 2) != 0) && k == s - b) rx_i = 1'b0;
        if (((v.lowpat & 4) != 0) && k == s - 2 * b) rx_i = 1'b0;
      end
      wr_en_i = (k == 1);
      if (k == 1) begin
        wr_presc_i = ~wr_presc_i;
        wr_ph1_i = ~wr_ph1_i;
        wr_ph2_i = ~wr_ph2_i;
        wr_triple_i = ~wr_triple_i;
      end
      if (k == 3) begin
        chk("R2 write ignored outside window presc", int'(rd_presc_o), v.presc);
        chk("R2 write ignored outside window ph2", int'(rd_ph2_o), v.ph2);
      end
      if (k == period + smp) cfg_req_i = 1'b1;
      if (sample_o && first_smp < 0) begin first_smp = k; smp_bit = int'(bit_o); end
      if (bit_start_o && k > 0 && second_start < 0) second_start = k;
      if (cfg_ack_o && ack_rise < 0) ack_rise = k;
      if (k > 2 * period && (sample_o || bit_start_o))
        chk("R9 strobes silent in config", 1, 0);
      @(posedge clk_i); #1;
    end
    wr_en_i = 1'b0;
    chk("R6 sample position", first_smp, smp);
    chk(v.triple != 0 ? "R7 majority bit value" : "R6 single bit value", smp_bit, exp_bit);
    chk(v.triple != 0 && v.ph2 == 0 ? "R8 clamped bit period" : "R5 bit period",
        second_start, period);
    chk("R3 ack rises after bit end", ack_rise, 2 * period);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 ack after reset", int'(cfg_ack_o), 1);
    chk("R1 presc after reset", int'(rd_presc_o), 0);
    chk("R1 ph1 after reset", int'(rd_ph1_o), 0);
    chk("R1 bit_o after reset", int'(bit_o), 1);
    chk("R1 strobes after reset", int'(sample_o) + int'(bit_start_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 idle while req held", int'(bit_start_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1 reset while running
    @(negedge clk_i);
    cfg_req_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R4 running before reset", int'(cfg_ack_o), 0);
    rst_ni = 1'b0;
    #1;
    chk("R1 ack on mid-run reset", int'(cfg_ack_o), 1);
    chk("R1 fields on mid-run reset", int'(rd_ph1_o) + int'(rd_ph2_o) + int'(rd_triple_o), 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end
endmodule